// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block is a register-mapped timer with a parameterised number of channels (two by default). All channels share one functional clock, and each channel has a 16-bit up-counter. A per-channel power-of-two prescaler divides that clock to produce count ticks. On each tick the counter advances by one. When it sits at the programmed limit, the next tick returns it to zero and raises an expiry flag. The channel then either keeps running without a gap (auto-reload) or stops itself (single-shot). The flag, gated by a per-channel interrupt-enable bit, drives a level interrupt line.

Software uses a simple synchronous bus with 16-bit data. A write is taken on the clock edge where select and write are both high. Read data is combinational from the address while select is high. Each channel owns a bank of four word registers. The banks repeat every 0x80 bytes, starting at 0x80. To start a fresh interval, software clears the run bit, writes a new limit and sets the run bit again.

Top module: `tmr_block`

## Requirements
- R1: After reset every register reads 0 and every interrupt line is low.
- R2: Channel n's bank sits at byte address 0x80 + n*0x80. Offset 0x0 holds control, 0x4 status, 0x8 limit and 0xC count. Any other address, including unaligned ones and those below 0x80 or past the last bank, reads 0 and ignores writes.
- R3: Control bit 8 is interrupt enable, bit 5 is run and bit 4 is single-shot (0 = auto-reload). Bits [3:0] are the prescaler code. All other control bits read 0.
- R4: With prescaler code k the count advances once every 2^k clocks. Codes 9 to 15 act as code 8. The first advance comes 2^k clocks after the write that sets run.
- R5: A control write that takes run from 0 to 1 resets the count and the prescaler phase to 0.
- R6: With limit L, the count runs 0..L, and the tick after L returns it to 0 and sets the expiry flag. In auto-reload mode this repeats every (L+1)*2^k clocks. Limits as small as 3 work.
- R7: In single-shot mode the run bit clears itself at expiry and the count then stays at 0.
- R8: Status bit 0 is the expiry flag. Writing 1 to it clears it, writing 0 leaves it unchanged, and an expiry in the same cycle as a clearing write wins.
- R9: Each channel's interrupt line equals its expiry flag ANDed with its interrupt-enable bit.
- R10: Channels run independently, each with its own prescaler code.
- R11: While run is 0 the count holds its value. Writes to the count register have no effect.
- R12: A limit of 0xFFFF gives a free-running counter that wraps over the whole 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock shared by all channels |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (10) | Byte address |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data, combinational from the address |
| irq | output | NCH (2) | Per-channel level interrupt |

## Verification
The bench targets the exact clock on which the count first advances and wraps, across random prescaler codes, including the clamped codes 9 to 15. An off-by-one in the prescaler phase or a missed phase reset on enable would show up there as a count that is one step early or late. It checks the single-shot case at the expiry edge and after it: a design that failed to clear run would keep counting and set the flag again. It also checks a full 16-bit wrap on one channel while the other channel runs with a different divisor. It writes to reserved, unaligned and out-of-range addresses. A loose decoder would let these writes corrupt a real bank or would read back non-zero data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CTRL_IE_BIT = 8;
   localparam int CTRL_EN_BIT = 5;
   localparam int CTRL_OS_BIT = 4;
   localparam int PSC_FIELD_W = 4;

   typedef enum logic [1:0] {
      RG_CTRL  = 2'd0,
      RG_STAT  = 2'd1,
      RG_LOAD  = 2'd2,
      RG_COUNT = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic                   irq_en;
      logic                   run;
      logic                   single;
      logic [PSC_FIELD_W-1:0] psc;
   } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC_MAX = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] code,
   output logic       tick
);
   localparam int DIV_W = PSC_MAX;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;
   logic [DIV_W:0]   full;
   logic [3:0]       eff;

   always_comb begin
      eff  = (int'(code) > PSC_MAX) ? 4'(PSC_MAX) : code;
      full = (DIV_W+1)'(1) << eff;
      mask = full[DIV_W-1:0] - DIV_W'(1);
      tick = run && ((div_q & mask) == mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    div_q <= '0;
      else if (!run) div_q <= '0;
      else           div_q <= div_q + DIV_W'(1);
   end

   // R4: a divided tick is never followed directly by another
   p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mask != '0) |=> (!tick || mask == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DW      = 16,
   parameter int PSC_MAX = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ctrl,
   input  logic          wr_stat,
   input  logic          wr_load,
   input  logic [DW-1:0] wdata,
   input  reg_sel_e      rsel,
   output logic [DW-1:0] rdata,
   output logic          irq
);
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] load_q;
   logic             flag_q;
   logic             tick;
   logic             at_load;
   logic             expire;
   logic             en_rise;

   tmr_prescaler #(.PSC_MAX(PSC_MAX)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctrl_q.run),
      .code (ctrl_q.psc),
      .tick (tick)
   );

   always_comb begin
      at_load = (count_q == load_q);
      expire  = tick && at_load;
      en_rise = wr_ctrl && wdata[CTRL_EN_BIT] && !ctrl_q.run;
      irq     = flag_q && ctrl_q.irq_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         count_q <= '0;
         load_q  <= '0;
         flag_q  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.irq_en <= wdata[CTRL_IE_BIT];
            ctrl_q.run    <= wdata[CTRL_EN_BIT];
            ctrl_q.single <= wdata[CTRL_OS_BIT];
            ctrl_q.psc    <= wdata[PSC_FIELD_W-1:0];
         end else if (expire && ctrl_q.single) begin
            ctrl_q.run <= 1'b0;
         end

         if (en_rise)   count_q <= '0;
         else if (tick) count_q <= at_load ? '0 : count_q + CNT_W'(1);

         if (expire)                     flag_q <= 1'b1;
         else if (wr_stat && wdata[0])   flag_q <= 1'b0;

         if (wr_load) load_q <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (rsel)
         RG_CTRL: begin
            rdata[CTRL_IE_BIT]       = ctrl_q.irq_en;
            rdata[CTRL_EN_BIT]       = ctrl_q.run;
            rdata[CTRL_OS_BIT]       = ctrl_q.single;
            rdata[PSC_FIELD_W-1:0]   = ctrl_q.psc;
         end
         RG_STAT:  rdata[0] = flag_q;
         RG_LOAD:  rdata    = DW'(load_q);
         RG_COUNT: rdata    = DW'(count_q);
         default:  rdata    = '0;
      endcase
   end

   // R6: the flag only rises from a tick taken at the limit
   p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick && count_q == load_q));
   // R4: a tick below the limit advances the count by exactly one
   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !at_load && !en_rise) |=> count_q == $past(count_q) + CNT_W'(1));
   // R7: single-shot expiry stops the channel
   p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q.single && !wr_ctrl) |=> (!ctrl_q.run && count_q == '0));
   // R11: a stopped channel holds its count
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !wr_ctrl) |=> $stable(count_q));
   // R8: a clearing write without a competing expiry drops the flag
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[0] && !expire) |=> !flag_q);
endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int AW     = 10,
   parameter int STRIDE = 128
) (
   input  logic [AW-1:0]                       addr,
   output logic                                hit,
   output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ch,
   output reg_sel_e                            rsel
);
   localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int SH     = $clog2(STRIDE);
   localparam int BANK_W = AW - SH;

   logic [BANK_W-1:0] bank;
   logic [SH-1:0]     off;

   always_comb begin
      bank = addr[AW-1:SH];
      off  = addr[SH-1:0];
      hit  = (bank != '0) && (int'(bank) <= NCH) &&
             (off[1:0] == 2'b00) && (off[SH-1:4] == '0);
      ch   = CH_W'(bank - BANK_W'(1));
      rsel = reg_sel_e'(off[3:2]);
   end
endmodule

// File: rtl/tmr_block.sv
module tmr_block
   import tmr_pkg::*;
#(
   parameter int NCH     = 2,
   parameter int CNT_W   = 16,
   parameter int DW      = 16,
   parameter int AW      = 10,
   parameter int STRIDE  = 128,
   parameter int PSC_MAX = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_sel,
   input  logic           bus_wr,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   output logic [NCH-1:0] irq
);
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (CNT_W > DW || CNT_W < 2) begin : g_bad_cnt
         $error("tmr_block: counter width must be 2..DW");
      end
      if (PSC_MAX < 1 || PSC_MAX > 15) begin : g_bad_psc
         $error("tmr_block: PSC_MAX must be 1..15");
      end
      if (STRIDE < 32 || (1 << $clog2(STRIDE)) != STRIDE) begin : g_bad_stride
         $error("tmr_block: STRIDE must be a power of two of at least 32");
      end
      if ((NCH + 1) * STRIDE > (1 << AW)) begin : g_bad_aw
         $error("tmr_block: address width too small for the channel banks");
      end
      if (DW <= CTRL_IE_BIT) begin : g_bad_dw
         $error("tmr_block: data width too small for the control fields");
      end
   endgenerate

   logic            hit;
   logic [CH_W-1:0] ch;
   reg_sel_e        rsel;
   logic [DW-1:0]   ch_rd [NCH];
   logic            wr_any;

   tmr_decode #(.NCH(NCH), .AW(AW), .STRIDE(STRIDE)) u_dec (
      .addr(bus_addr),
      .hit (hit),
      .ch  (ch),
      .rsel(rsel)
   );

   assign wr_any = bus_sel && bus_wr && hit;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic mine;
         assign mine = wr_any && (ch == CH_W'(i));
         tmr_channel #(.CNT_W(CNT_W), .DW(DW), .PSC_MAX(PSC_MAX)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_ctrl(mine && rsel == RG_CTRL),
            .wr_stat(mine && rsel == RG_STAT),
            .wr_load(mine && rsel == RG_LOAD),
            .wdata  (bus_wdata),
            .rsel   (rsel),
            .rdata  (ch_rd[i]),
            .irq    (irq[i])
         );
      end
   endgenerate

   assign bus_rdata = (bus_sel && hit) ? ch_rd[ch] : '0;
endmodule

// File: tb/tmr_block_test.sv
module tmr_block_test;
   localparam logic [15:0] IE = 16'h0100;
   localparam logic [15:0] EN = 16'h0020;
   localparam logic [15:0] OS = 16'h0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bsel = 1'b0;
   logic        bwr = 1'b0;
   logic [9:0]  baddr = '0;
   logic [15:0] bwdata = '0;
   logic [15:0] brdata;
   logic [1:0]  irq;

   int total = 0;
   int bad = 0;

   tmr_block uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_wr(bwr),
      .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(brdata), .irq(irq)
   );

   always #10 clk = ~clk;

   function automatic logic [9:0] ra(int ch, int off);
      return 10'(128 + ch * 128 + off);
   endfunction
   function automatic int eff(int code);
      return (code > 8) ? 8 : code;
   endfunction
   function automatic logic [15:0] exp_cnt(int m, int k, int lim);
      return 16'((m >> k) % (lim + 1));
   endfunction
   function automatic logic [15:0] exp_flag(int m, int k, int lim);
      return (m >= ((lim + 1) << k)) ? 16'd1 : 16'd0;
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [9:0] a, logic [15:0] d);
      bsel = 1'b1; bwr = 1'b1; baddr = a; bwdata = d;
      @(posedge clk);
      @(negedge clk);
      bsel = 1'b0; bwr = 1'b0;
   endtask

   task automatic rd(logic [9:0] a, output logic [15:0] d);
      bsel = 1'b1; bwr = 1'b0; baddr = a;
      #1;
      d = brdata;
      bsel = 1'b0;
   endtask

   task automatic waitc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(20 * 190000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] v, c0;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int ch = 0; ch < 2; ch++)
         for (int o = 0; o < 16; o += 4) begin
            rd(ra(ch, o), v); chk("R1 reset reg", v, 16'h0);
         end
      chk("R1 irq", {14'h0, irq}, 16'h0);

      // R2 reserved / unaligned / out-of-range addresses
      wr(10'h090, 16'hFFFF);
      wr(10'h000, 16'hFFFF);
      wr(10'h180, 16'hFFFF);
      wr(10'h082, 16'hFFFF);
      wr(10'h08A, 16'hFFFF);
      rd(10'h090, v); chk("R2 reserved 0x090", v, 16'h0);
      rd(10'h000, v); chk("R2 reserved 0x000", v, 16'h0);
      rd(10'h180, v); chk("R2 beyond last bank", v, 16'h0);
      rd(10'h082, v); chk("R2 unaligned", v, 16'h0);
      rd(ra(0, 0), v); chk("R2 ch0 ctrl untouched", v, 16'h0);
      rd(ra(0, 8), v); chk("R2 ch0 limit untouched", v, 16'h0);

      // R7 single-shot with R9 interrupt, prescaler code 1, limit 3
      wr(ra(0, 8), 16'd3);
      wr(ra(0, 0), IE | EN | OS | 16'd1);
      waitc(7);
      rd(ra(0, 12), v); chk("R6 count at limit", v, 16'd3);
      rd(ra(0, 4), v); chk("R6 no flag before wrap", v, 16'd0);
      chk("R9 irq low before expiry", {15'h0, irq[0]}, 16'd0);
      waitc(1);
      rd(ra(0, 12), v); chk("R6 wrap to 0", v, 16'd0);
      rd(ra(0, 4), v); chk("R6 flag at expiry", v, 16'd1);
      rd(ra(0, 0), v); chk("R7 run cleared", v, IE | OS | 16'd1);
      chk("R9 irq high", {15'h0, irq[0]}, 16'd1);
      waitc(20);
      rd(ra(0, 12), v); chk("R7 count stays 0", v, 16'd0);
      wr(ra(0, 4), 16'h0000);
      rd(ra(0, 4), v); chk("R8 write 0 keeps flag", v, 16'd1);
      wr(ra(0, 4), 16'h0001);
      rd(ra(0, 4), v); chk("R8 write 1 clears", v, 16'd0);
      chk("R9 irq follows clear", {15'h0, irq[0]}, 16'd0);

      // R11 hold while stopped, count writes ignored
      wr(ra(0, 8), 16'd40);
      wr(ra(0, 0), EN);
      waitc(9);
      wr(ra(0, 0), 16'h0000);
      rd(ra(0, 12), c0);
      waitc(10);
      rd(ra(0, 12), v); chk("R11 hold", v, c0);
      wr(ra(0, 12), 16'h1234);
      rd(ra(0, 12), v); chk("R11 count write ignored", v, c0);

      // R4 R5 R6 R9 random intervals, restarted mid-run each time
      for (int it = 0; it < 24; it++) begin
         int ch, code, k, lim, m;
         ch = int'($urandom % 2);
         code = int'($urandom % 6);
         if (code == 5) begin
            code = 9 + int'($urandom % 7);
            lim = 3 + int'($urandom % 4);
         end else begin
            lim = 3 + int'($urandom % 18);
         end
         k = eff(code);
         m = int'($urandom % (3 * ((lim + 1) << k)));
         wr(ra(ch, 0), 16'h0000);
         wr(ra(ch, 4), 16'h0001);
         wr(ra(ch, 8), 16'(lim));
         wr(ra(ch, 0), EN | 16'(code));
         waitc(m);
         rd(ra(ch, 12), v); chk("R4 R5 count phase", v, exp_cnt(m, k, lim));
         rd(ra(ch, 4), v); chk("R6 flag", v, exp_flag(m, k, lim));
         chk("R9 irq masked", {15'h0, irq[ch]}, 16'd0);
      end

      // R10 R12 independent channels, full 16-bit wrap on ch1
      wr(ra(0, 0), 16'h0000);
      wr(ra(1, 0), 16'h0000);
      wr(ra(0, 4), 16'h0001);
      wr(ra(1, 4), 16'h0001);
      wr(ra(1, 8), 16'hFFFF);
      wr(ra(1, 0), EN);
      wr(ra(0, 8), 16'd5);
      wr(ra(0, 0), EN | 16'd2);
      waitc(30);
      rd(ra(0, 12), v); chk("R10 ch0 count", v, exp_cnt(30, 2, 5));
      rd(ra(1, 12), v); chk("R10 ch1 count", v, exp_cnt(32, 0, 65535));
      waitc(65514);
      rd(ra(1, 12), v); chk("R12 wrapped count", v, 16'd10);
      rd(ra(1, 4), v); chk("R12 wrap flag", v, 16'd1);
      rd(ra(0, 12), v); chk("R10 ch0 after long run", v, exp_cnt(65544, 2, 5));

      // R3 unused control bits read 0
      wr(ra(1, 0), 16'hFEEF);
      rd(ra(1, 0), v); chk("R3 control fields", v, 16'h002F);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule